// File: doc/BRIEF.md
# AHB Burst Transfer Sequencer

This block is the address-phase engine of a bus master. A requester hands it one transfer description: a start address, a transfer size, a read/write flag, a beat count of 1, 4, 8 or 16, and a choice between incrementing and wrapping addresses. The block then drives the AHB address and control outputs beat by beat. It moves to the next beat each time `hready` is high and freezes everything while `hready` is low. When it has nothing to do it drives the IDLE transfer type.

Each beat's address and control are on the bus one cycle before that beat's data phase. For write bursts, the requester presents the beat's data on `wrData` during the beat's address phase. The block registers that data when the address phase is accepted and drives it on `hwdata` during the data phase that follows. Wrapping bursts keep their addresses inside an aligned window. The window size in bytes is the transfer size in bytes multiplied by the beat count.

Top module: `ahbBurstSeq`

## Requirements
- R1: After a synchronous reset (`rstN` low at a clock edge), `htrans` is IDLE (2'b00) and `busy` is low. Both stay so for as long as no request is given, and a reset in the middle of a burst abandons that burst.
- R2: `htrans` never carries the BUSY code 2'b01.
- R3: A request accepted at a clock edge makes the next cycle show its first beat with `htrans` = NONSEQ (2'b10) and `haddr` equal to the request address. A request with a beat count of 1 is a single NONSEQ beat.
- R4: Every beat after the first shows `htrans` = SEQ (2'b11). In an incrementing burst its address is the previous beat's address plus 2^`hsize` bytes.
- R5: In a wrapping burst, beat k has the address base + ((start − base + k·2^size) mod B), where B = 2^size × beats and base is the start address rounded down to a multiple of B.
- R6: `hwrite`, `hsize` and `hburst` stay constant across all beats of a burst. `hburst` is 3'b000 for a single beat and otherwise {`reqBeats`, ~`reqWrap`}, so that WRAP4=010, INCR4=011, WRAP8=100, INCR8=101, WRAP16=110 and INCR16=111. `reqBeats` is coded 0=1, 1=4, 2=8, 3=16 beats, and the wrap flag of a single beat is ignored.
- R7: While `hready` is low, `htrans`, `haddr` and the control outputs keep their values and the beat does not advance.
- R8: For a write, `hwdata` in the cycle after an accepted address phase equals the `wrData` that was present during that address phase. It holds that value while `hready` stays low.
- R9: `busy` is high from the cycle after acceptance until the final address phase is accepted. A request given while `busy` is high is ignored.
- R10: Exactly the requested number of address phases are accepted, and `htrans` returns to IDLE in the cycle after the final one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when `busy` is low |
| reqAddr | input | ADDR_W | Start address of the burst |
| reqSize | input | 3 | Transfer size as log2 of bytes, at most log2(DATA_W/8) |
| reqWrite | input | 1 | 1 = write burst |
| reqBeats | input | 2 | Beat count code: 0=1, 1=4, 2=8, 3=16 |
| reqWrap | input | 1 | 1 = wrapping addresses, 0 = incrementing |
| wrData | input | DATA_W | Write data for the beat currently in its address phase |
| hready | input | 1 | Bus ready; the current address phase is accepted when high |
| busy | output | 1 | A burst is in progress; new requests are refused |
| htrans | output | 2 | Transfer type: IDLE, NONSEQ or SEQ |
| haddr | output | ADDR_W | Beat address |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type code |
| hwdata | output | DATA_W | Write data for the beat in its data phase |

## Verification
A wrong beat counter shows on the ports within one accepted beat. `htrans` goes IDLE too early or stays SEQ past the last beat, and the bench catches this in the first cycle after the final expected address phase. A corrupt address or wrap mask changes `haddr` on the first SEQ beat. Wrapping tests start in the middle of their window so that the wrap point is reached within the burst. A stale or mis-held register is exposed by bursts with wait states placed on both the address and the data phases: a frozen `haddr` or `hwdata` that moves, or a request taken while busy, shows one cycle later.

// File: rtl/ahbSeqPkg.sv
package ahbSeqPkg;

  typedef enum logic [1:0] {
    TR_IDLE = 2'b00,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } transE;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;     // latch a new request
    logic step;     // move the address to the next beat
    logic capData;  // register write data for the coming data phase
  } seqStrobeT;

  // Burst type code presented on hburst
  function automatic logic [2:0] burstCode(input logic [1:0] beatsCode, input logic wrap);
    return (beatsCode == 2'd0) ? 3'b000 : {beatsCode, ~wrap};
  endfunction

endpackage

// File: rtl/ahbSeqCtrl.sv
module ahbSeqCtrl
  import ahbSeqPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqBeats,
  input  logic             hready,
  input  logic             curWrite,
  output seqStrobeT        strobe,
  output logic             busy,
  output logic [1:0]       htrans
);

  logic             active;
  logic             first;
  logic [CNT_W-1:0] beatsLeft;
  logic             lastBeat;
  logic             accept;
  logic             finish;
  logic [CNT_W:0]   loadSpan;
  logic [CNT_W-1:0] loadCount;
  logic [2:0]       shiftAmt;

  assign lastBeat = (beatsLeft == '0);
  assign accept   = active & hready;
  assign finish   = accept & lastBeat;

  // beats - 1 from the beat code: 0 -> 0, else 2^(code+1) - 1
  always_comb begin
    shiftAmt  = {1'b0, reqBeats} + 3'd1;
    loadSpan  = ({{CNT_W{1'b0}}, 1'b1} << shiftAmt) - {{CNT_W{1'b0}}, 1'b1};
    loadCount = (reqBeats == 2'd0) ? '0 : loadSpan[CNT_W-1:0];
  end

  always_comb begin
    strobe.load    = reqValid & ~active;
    strobe.step    = accept & ~lastBeat;
    strobe.capData = accept & curWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      first     <= 1'b0;
      beatsLeft <= '0;
    end else if (strobe.load) begin
      active    <= 1'b1;
      first     <= 1'b1;
      beatsLeft <= loadCount;
    end else if (strobe.step) begin
      first     <= 1'b0;
      beatsLeft <= beatsLeft - {{(CNT_W-1){1'b0}}, 1'b1};
    end else if (finish) begin
      active    <= 1'b0;
      first     <= 1'b0;
    end
  end

  always_comb begin
    if (!active)    htrans = TR_IDLE;
    else if (first) htrans = TR_NSEQ;
    else            htrans = TR_SEQ;
  end

  assign busy = active;

  // ---------------- assertions ----------------
  assert_no_busy_code_R2: assert property (@(posedge clk) disable iff (!rstN)
    htrans != 2'b01);

  assert_first_nonseq_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (htrans == TR_NSEQ) && busy);

  assert_wait_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (active && !hready) |=> $stable(htrans) && $stable(beatsLeft));

  assert_ignore_when_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (active && !first && reqValid) |=> htrans != TR_NSEQ);

  assert_idle_after_last_R10: assert property (@(posedge clk) disable iff (!rstN)
    finish |=> (htrans == TR_IDLE) && !busy);

endmodule

// File: rtl/ahbSeqDatapath.sv
module ahbSeqDatapath
  import ahbSeqPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  input  logic [1:0]        reqBeats,
  input  logic              reqWrap,
  input  logic [DATA_W-1:0] wrData,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata
);

  logic [ADDR_W-1:0] addrReg;
  logic [2:0]        sizeReg;
  logic              writeReg;
  logic [1:0]        beatsReg;
  logic              wrapReg;
  logic [DATA_W-1:0] dataReg;

  logic [ADDR_W-1:0] incBytes;
  logic [ADDR_W-1:0] sumAddr;
  logic [ADDR_W-1:0] wrapMask;
  logic [ADDR_W-1:0] nextAddr;
  logic [3:0]        winLog2;

  // Next-beat address: increment, or increment inside the aligned window
  always_comb begin
    incBytes = {{(ADDR_W-1){1'b0}}, 1'b1} << sizeReg;
    sumAddr  = addrReg + incBytes;
    winLog2  = {1'b0, sizeReg} + {2'b00, beatsReg} + 4'd1;
    wrapMask = ({{(ADDR_W-1){1'b0}}, 1'b1} << winLog2) - {{(ADDR_W-1){1'b0}}, 1'b1};
    nextAddr = wrapReg ? ((addrReg & ~wrapMask) | (sumAddr & wrapMask)) : sumAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      sizeReg  <= '0;
      writeReg <= 1'b0;
      beatsReg <= '0;
      wrapReg  <= 1'b0;
    end else if (strobe.load) begin
      addrReg  <= reqAddr;
      sizeReg  <= reqSize;
      writeReg <= reqWrite;
      beatsReg <= reqBeats;
      wrapReg  <= reqWrap & (reqBeats != 2'd0);
    end else if (strobe.step) begin
      addrReg  <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              dataReg <= '0;
    else if (strobe.capData) dataReg <= wrData;
  end

  assign haddr  = addrReg;
  assign hwrite = writeReg;
  assign hsize  = sizeReg;
  assign hburst = burstCode(beatsReg, wrapReg);
  assign hwdata = dataReg;

  // ---------------- assertions ----------------
  assert_incr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && !wrapReg) |=> haddr == ($past(haddr) + $past(incBytes)));

  assert_wrap_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && wrapReg) |=> ((haddr ^ $past(haddr)) & ~wrapMask) == '0);

  assert_ctrl_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(hwrite) && $stable(hsize) && $stable(hburst));

  assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.step) |=> $stable(haddr));

  assert_wdata_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capData |=> $stable(hwdata));

endmodule

// File: rtl/ahbBurstSeq.sv
module ahbBurstSeq
  import ahbSeqPkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_BEATS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [2:0]        reqSize,
  input  logic              reqWrite,
  input  logic [1:0]        reqBeats,
  input  logic              reqWrap,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hready,
  output logic              busy,
  output logic [1:0]        htrans,
  output logic [ADDR_W-1:0] haddr,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [DATA_W-1:0] hwdata
);

  localparam int CNT_W = $clog2(MAX_BEATS);

  seqStrobeT strobe;

  ahbSeqCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqBeats (reqBeats),
    .hready   (hready),
    .curWrite (hwrite),
    .strobe   (strobe),
    .busy     (busy),
    .htrans   (htrans)
  );

  ahbSeqDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .reqWrite (reqWrite),
    .reqBeats (reqBeats),
    .reqWrap  (reqWrap),
    .wrData   (wrData),
    .haddr    (haddr),
    .hwrite   (hwrite),
    .hsize    (hsize),
    .hburst   (hburst),
    .hwdata   (hwdata)
  );

endmodule

// File: tb/sim_ahbBurstSeq.sv
module sim_ahbBurstSeq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [2:0]  reqSize = '0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqBeats = '0;
  logic        reqWrap = 1'b0;
  logic [31:0] wrData = '0;
  logic        hready = 1'b1;
  logic        busy;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [2:0]  hburst;
  logic [31:0] hwdata;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ahbBurstSeq u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqBeats(reqBeats),
    .reqWrap(reqWrap), .wrData(wrData), .hready(hready), .busy(busy),
    .htrans(htrans), .haddr(haddr), .hwrite(hwrite), .hsize(hsize),
    .hburst(hburst), .hwdata(hwdata)
  );

  task automatic chkEq(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expAddr(input logic [31:0] start, input int size,
                                          input int beats, input bit wrap, input int k);
    int unsigned bytes = 1 << size;
    int unsigned bound, base;
    if (!wrap || beats == 1) return start + k * bytes;
    bound = bytes * beats;
    base  = start - (start % bound);
    return base + ((start - base) + k * bytes) % bound;
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    reqValid = 1'b0;
    hready = 1'b1;
    repeat (2) @(negedge clk);
    chkEq("R1", "htrans in reset", {30'd0, htrans}, 32'd0);
    chkEq("R1", "busy in reset", {31'd0, busy}, 32'd0);
    rstN = 1'b1;
  endtask

  task automatic testIdleHold();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chkEq("R1", "htrans idle", {30'd0, htrans}, 32'd0);
      chkEq("R1", "busy idle", {31'd0, busy}, 32'd0);
    end
  endtask

  // One burst; waitMode inserts wait states, poke offers a request mid-burst
  task automatic runBurst(input logic [31:0] addr, input int size, input bit wr,
                          input int code, input bit wrap, input bit waitMode,
                          input bit poke);
    int beats = (code == 0) ? 1 : (1 << (code + 1));
    logic [2:0] expBurst = (code == 0) ? 3'b000 : {code[1:0], ~wrap};
    int k = 0;
    int c = 0;
    bit pend = 1'b0;
    bit waited = 1'b0;
    bit rdy;
    logic [31:0] pendData = '0;
    logic [31:0] prevAddr = '0;
    logic [31:0] beatData;

    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = size[2:0]; reqWrite = wr;
    reqBeats = code[1:0]; reqWrap = wrap; hready = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    while (k < beats) begin
      chkEq(k == 0 ? "R3" : "R4", "htrans", {30'd0, htrans}, k == 0 ? 32'd2 : 32'd3);
      chkEq("R2", "no busy code", {31'd0, htrans == 2'b01}, 32'd0);
      chkEq(wrap ? "R5" : "R4", "haddr", haddr, expAddr(addr, size, beats, wrap, k));
      chkEq("R6", "ctrl", {25'd0, hwrite, hsize, hburst}, {25'd0, wr, size[2:0], expBurst});
      chkEq("R9", "busy high", {31'd0, busy}, 32'd1);
      if (waited) chkEq("R7", "haddr held", haddr, prevAddr);
      if (pend) chkEq("R8", "hwdata", hwdata, pendData);
      rdy = !(waitMode && (c % 3 == 1));
      hready = rdy;
      beatData = {8'hA5, addr[15:0], k[7:0]};
      wrData = beatData;
      if (poke && k == 1) begin
        reqValid = 1'b1; reqAddr = addr ^ 32'h0000_0F00; reqWrite = ~wr;
      end else begin
        reqValid = 1'b0;
      end
      prevAddr = haddr;
      @(negedge clk);
      c++;
      waited = !rdy;
      if (rdy) begin
        pend = wr;
        pendData = beatData;
        k++;
      end
    end
    reqValid = 1'b0;
    chkEq("R10", "htrans idle after last", {30'd0, htrans}, 32'd0);
    chkEq("R9", "busy low after last", {31'd0, busy}, 32'd0);
    if (pend) chkEq("R8", "last hwdata", hwdata, pendData);
    hready = 1'b1;
    @(negedge clk);
    chkEq(poke ? "R9" : "R10", "stays idle", {30'd0, htrans}, 32'd0);
  endtask

  task automatic testMidReset();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0000_3000; reqSize = 3'd2; reqWrite = 1'b0;
    reqBeats = 2'd2; reqWrap = 1'b0; hready = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (2) @(negedge clk);
    chkEq("R4", "mid burst SEQ", {30'd0, htrans}, 32'd3);
    doReset();
    @(negedge clk);
    chkEq("R1", "idle after mid reset", {30'd0, htrans}, 32'd0);
    chkEq("R1", "busy after mid reset", {31'd0, busy}, 32'd0);
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  initial begin
    doReset();
    testIdleHold();
    runBurst(32'h0000_1000, 2, 1'b1, 0, 1'b0, 1'b0, 1'b0); // single write
    runBurst(32'h0000_2000, 2, 1'b0, 1, 1'b0, 1'b0, 1'b0); // INCR4 word
    runBurst(32'h0000_0038, 2, 1'b1, 1, 1'b1, 1'b0, 1'b0); // WRAP4 word mid-window
    runBurst(32'h0000_0106, 1, 1'b0, 2, 1'b1, 1'b0, 1'b0); // WRAP8 halfword
    runBurst(32'h0000_0041, 0, 1'b1, 2, 1'b0, 1'b1, 1'b0); // INCR8 byte, waits
    runBurst(32'h0000_02F5, 0, 1'b1, 3, 1'b1, 1'b1, 1'b1); // WRAP16 byte, waits, poke
    runBurst(32'h0000_0400, 2, 1'b1, 3, 1'b0, 1'b1, 1'b0); // INCR16 word, waits
    runBurst(32'h0000_0504, 2, 1'b0, 0, 1'b1, 1'b0, 1'b0); // single, wrap flag ignored
    runBurst(32'h0000_0A3C, 2, 1'b0, 1, 1'b1, 1'b1, 1'b1); // WRAP4 read, waits, poke
    testMidReset();
    testIdleHold();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      report();
      $finish;
    end
  end

endmodule